// File: doc/BRIEF.md
# I2C Target with Alert-Response Arbitration

This block is the bus-side front end of a sensor-style peripheral. It sits on a two-wire serial bus as a target only. It never drives the clock line, and it pulls the data line low through an output-enable and otherwise leaves it released. It samples both lines into the system clock domain and finds the start and stop conditions. It then shifts in an address byte, compares the 7-bit part with its parameterised address, and moves bytes in or out through a plain byte port.

The block also takes part in alert polling. While the alert input is latched, it acknowledges the read of the shared alert-response address (0x19). It then returns its own address followed by a status bit, and checks the wired-AND line on every clock rise. The lowest address therefore wins, and only a target that sends all eight bits without losing raises `alert_won`, which the surrounding logic uses to clear its alert latch. An idle timer returns the block to rest when the bus stops moving in the middle of a transfer.

States:
- `ST_IDLE`: at rest.
- `ST_ADDR`: receiving the address byte.
- `ST_ADDR_ACK`: acknowledging the address.
- `ST_RX_DATA` and `ST_RX_ACK`: receiving a write byte and acknowledging it.
- `ST_TX_DATA` and `ST_TX_MACK`: sending a read byte and then sampling the controller's acknowledge.
- `ST_TX_ARA`: sending the alert reply.
- `ST_IGNORE`: inactive until the next start condition.

Transitions:
- A start condition moves any state to `ST_ADDR`.
- A stop condition or the timeout moves any state to `ST_IDLE`.
- From `ST_ADDR`, the eighth rise leads to `ST_ADDR_ACK` on an own-address or armed alert match, and to `ST_IGNORE` otherwise.
- From `ST_ADDR_ACK`, the falling edge after the ninth clock leads to `ST_RX_DATA`, `ST_TX_DATA` or `ST_TX_ARA`, as the matched mode selects.
- `ST_RX_DATA` goes to `ST_RX_ACK` on the eighth rise and returns to `ST_RX_DATA` after the ninth clock.
- `ST_TX_DATA` goes to `ST_TX_MACK` after the eighth bit.
- From `ST_TX_MACK`, an acknowledge leads back to `ST_TX_DATA` and a not-acknowledge leads to `ST_IGNORE`.
- `ST_TX_ARA` goes to `ST_IGNORE` on a lost bit or after the eighth bit.

Top module: `i2c_alert_target`

## Requirements
- R1: A start condition (SDA falls while SCL is high) begins a new address byte from any state. A stop condition (SDA rises while SCL is high) returns the block to idle.
- R2: Bits are sampled on SCL rising edges, most significant bit first. If the upper 7 bits of the address byte equal `ADDR`, the block acknowledges by holding SDA low through the ninth clock. Bit 0 selects the direction: 1 means read and 0 means write.
- R3: An address byte that matches neither its own address nor an armed alert request is not acknowledged. The block then acknowledges no byte and raises no strobe until the next start condition.
- R4: In a write, the block acknowledges each data byte and presents it on `wr_data` with a one-cycle `wr_valid` pulse.
- R5: In a read, the block loads each byte from `rd_data` and pulses `rd_req` in the same cycle. It sends the byte MSB first. A controller acknowledge leads to the next byte, and a not-acknowledge ends driving.
- R6: `sda_oe` changes only while the synchronised SCL is low, apart from a timeout release.
- R7: The byte 0x19 is acknowledged only while `alert_latched` is 1. Otherwise it is treated as a mismatch.
- R8: The alert reply is `{ADDR, alert_status}`, MSB first. `alert_won` pulses for one cycle when all eight bits are sent without a loss.
- R9: If the block releases SDA for a 1 but samples a 0, it stops driving for the rest of the byte and gives no `alert_won` pulse.
- R10: After `CLK_HZ/1000*TIMEOUT_MS` cycles with no line activity while not idle, the block returns to idle and releases SDA.
- R11: In reset and in idle, SDA is released (`sda_oe` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| wr_valid | output | 1 | One-cycle strobe for a received write byte |
| wr_data | output | 8 | Received write byte |
| rd_req | output | 1 | One-cycle strobe when `rd_data` is taken |
| rd_data | input | 8 | Byte to send in a read |
| alert_latched | input | 1 | Alert is pending; arms the alert response |
| alert_status | input | 1 | Last bit of the alert reply |
| alert_won | output | 1 | One-cycle pulse: reply sent without losing arbitration |

## Verification
The bench places a second, lower-addressed target on the wired-AND line during an alert poll. A design that kept driving after a loss, or that flagged a win anyway, would corrupt the reply or clear an alert that belongs to another device. It also polls with the alert down, to catch a block that answers 0x19 unconditionally. The bench sends a wrong address followed by data, which exposes a block that acknowledges or strobes bytes meant for others. Finally, it stalls the bus while the block holds the acknowledge low, so a missing or mis-sized idle timer shows up as a line stuck low or released too early.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RX_DATA, ST_RX_ACK,
        ST_TX_DATA, ST_TX_MACK, ST_TX_ARA, ST_IGNORE
    } state_t;

    typedef enum logic [1:0] {MD_WRITE, MD_READ, MD_ALERT} mode_t;

    localparam logic [7:0] ALERT_RESP_BYTE = 8'h19;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_chg,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] prev;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign lvl[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '1;
        else        prev <= lvl;
    end

    assign scl_s     = lvl[1];
    assign sda_s     = lvl[0];
    assign scl_rise  = lvl[1] & ~prev[1];
    assign scl_fall  = ~lvl[1] & prev[1];
    assign sda_chg   = lvl[0] ^ prev[0];
    assign start_det = lvl[1] & prev[1] & prev[0] & ~lvl[0];
    assign stop_det  = lvl[1] & prev[1] & ~prev[0] & lvl[0];
endmodule

// File: rtl/i2ct_idle_timer.sv
module i2ct_idle_timer #(
    parameter int unsigned LIMIT = 5000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic activity,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           cnt <= '0;
        else if (!busy || activity || expired) cnt <= '0;
        else                                  cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == W'(LIMIT));
endmodule

// File: rtl/i2c_alert_target.sv
module i2c_alert_target
    import i2ct_pkg::*;
#(
    parameter logic [6:0]  ADDR        = 7'h48,
    parameter int unsigned CLK_HZ      = 200000000,
    parameter int unsigned TIMEOUT_MS  = 25,
    parameter int          SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic       wr_valid,
    output logic [7:0] wr_data,
    output logic       rd_req,
    input  logic [7:0] rd_data,
    input  logic       alert_latched,
    input  logic       alert_status,
    output logic       alert_won
);
    localparam int unsigned TO_CYC = CLK_HZ / 1000 * TIMEOUT_MS;
    localparam int          BITS   = 8;
    localparam int          CNT_W  = $clog2(BITS + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BITS - 1);
    localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BITS);

    logic scl_s, sda_s, scl_rise, scl_fall, sda_chg, start_det, stop_det;
    logic to_hit;

    state_t state, nxt;
    mode_t  mode_q;
    logic [CNT_W-1:0] bit_cnt;
    logic [7:0] shreg, txbyte, rx_byte;
    logic ack_seen, sda_oe_q;
    logic own_hit, ara_hit, byte_end, arb_lost;

    i2ct_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_chg(sda_chg), .start_det(start_det), .stop_det(stop_det)
    );

    i2ct_idle_timer #(.LIMIT(TO_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .busy(state != ST_IDLE),
        .activity(scl_rise | scl_fall | sda_chg), .expired(to_hit)
    );

    assign rx_byte  = {shreg[6:0], sda_s};
    assign own_hit  = (rx_byte[7:1] == ADDR);
    assign ara_hit  = (rx_byte == ALERT_RESP_BYTE) && alert_latched;
    assign byte_end = scl_rise && (bit_cnt == LAST_BIT);
    assign arb_lost = scl_rise && txbyte[7] && !sda_s;

    // next-state logic
    always_comb begin
        nxt = state;
        if (to_hit || stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:    nxt = ST_IDLE;
                ST_ADDR:    if (byte_end) nxt = (own_hit || ara_hit) ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall && ack_seen) begin
                    case (mode_q)
                        MD_READ:  nxt = ST_TX_DATA;
                        MD_ALERT: nxt = ST_TX_ARA;
                        default:  nxt = ST_RX_DATA;
                    endcase
                end
                ST_RX_DATA: if (byte_end) nxt = ST_RX_ACK;
                ST_RX_ACK:  if (scl_fall && ack_seen) nxt = ST_RX_DATA;
                ST_TX_DATA: if (scl_fall && bit_cnt == ALL_BITS) nxt = ST_TX_MACK;
                ST_TX_MACK: begin
                    if (scl_rise && sda_s)          nxt = ST_IGNORE;
                    else if (scl_fall && ack_seen)  nxt = ST_TX_DATA;
                end
                ST_TX_ARA: begin
                    if (arb_lost)                                nxt = ST_IGNORE;
                    else if (scl_fall && bit_cnt == ALL_BITS)    nxt = ST_IGNORE;
                end
                ST_IGNORE:  nxt = ST_IGNORE;
                default:    nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe_q  <= 1'b0;
            bit_cnt   <= '0;
            shreg     <= '0;
            txbyte    <= '0;
            ack_seen  <= 1'b0;
            mode_q    <= MD_WRITE;
            wr_valid  <= 1'b0;
            wr_data   <= '0;
            rd_req    <= 1'b0;
            alert_won <= 1'b0;
        end else begin
            wr_valid  <= 1'b0;
            rd_req    <= 1'b0;
            alert_won <= 1'b0;
            if (to_hit || stop_det || start_det) begin
                sda_oe_q <= 1'b0;
                bit_cnt  <= '0;
                ack_seen <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_RX_DATA: if (scl_rise) begin
                        shreg   <= rx_byte;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (byte_end) begin
                            bit_cnt  <= '0;
                            ack_seen <= 1'b0;
                            if (state == ST_ADDR) begin
                                mode_q <= own_hit ? (rx_byte[0] ? MD_READ : MD_WRITE) : MD_ALERT;
                            end else begin
                                wr_valid <= 1'b1;
                                wr_data  <= rx_byte;
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_RX_ACK: begin
                        if (scl_rise) begin
                            ack_seen <= 1'b1;
                        end else if (scl_fall && !ack_seen) begin
                            sda_oe_q <= 1'b1;
                        end else if (scl_fall) begin
                            sda_oe_q <= 1'b0;
                            ack_seen <= 1'b0;
                            bit_cnt  <= '0;
                            if (state == ST_ADDR_ACK && mode_q == MD_READ) begin
                                txbyte   <= rd_data;
                                rd_req   <= 1'b1;
                                sda_oe_q <= !rd_data[7];
                            end else if (state == ST_ADDR_ACK && mode_q == MD_ALERT) begin
                                txbyte   <= {ADDR, alert_status};
                                sda_oe_q <= !ADDR[6];
                            end
                        end
                    end
                    ST_TX_DATA, ST_TX_ARA: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                            if (state == ST_TX_ARA && arb_lost) sda_oe_q <= 1'b0;
                            else if (state == ST_TX_ARA && bit_cnt == LAST_BIT) alert_won <= 1'b1;
                        end else if (scl_fall) begin
                            if (bit_cnt == ALL_BITS) begin
                                sda_oe_q <= 1'b0;
                                ack_seen <= 1'b0;
                            end else begin
                                txbyte   <= {txbyte[6:0], 1'b0};
                                sda_oe_q <= !txbyte[6];
                            end
                        end
                    end
                    ST_TX_MACK: begin
                        if (scl_rise) begin
                            ack_seen <= !sda_s;
                        end else if (scl_fall && ack_seen) begin
                            ack_seen <= 1'b0;
                            bit_cnt  <= '0;
                            txbyte   <= rd_data;
                            rd_req   <= 1'b1;
                            sda_oe_q <= !rd_data[7];
                        end
                    end
                    default: sda_oe_q <= 1'b0;
                endcase
            end
        end
    end

    assign sda_oe = sda_oe_q;

    assert_sda_low_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_q) |-> (!$past(scl_s) || $past(to_hit)));
    assert_idle_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe_q);
    assert_timeout_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        to_hit |=> (state == ST_IDLE));
    assert_wr_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);
    assert_won_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        alert_won |=> !alert_won);
    assert_lost_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !alert_won);
endmodule

// File: tb/sim_i2c_alert_target.sv
module sim_i2c_alert_target;
    localparam int H = 12;
    localparam logic [6:0] OWN = 7'h48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, oth_low = 1'b0;
    logic sda_oe, wr_valid, rd_req, alert_won;
    logic [7:0] wr_data, rd_data;
    logic alert_latched = 1'b0, alert_status = 1'b0;
    logic sda_bus;
    int errors = 0, checks = 0, won_cnt = 0, rd_cnt = 0;
    bit done = 0;
    logic [7:0] wr_log[$];

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe & ~oth_low;
    assign rd_data = 8'hC3 ^ rd_cnt[7:0];

    i2c_alert_target #(.ADDR(OWN), .CLK_HZ(200000), .TIMEOUT_MS(25)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data),
        .alert_latched(alert_latched), .alert_status(alert_status), .alert_won(alert_won)
    );

    always @(posedge clk) begin
        if (wr_valid) wr_log.push_back(wr_data);
        if (alert_won) won_cnt <= won_cnt + 1;
        if (rd_req) rd_cnt <= rd_cnt + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (H) @(negedge clk);
    endtask

    task automatic bit_cyc(input logic mb, input logic oth, output logic seen);
        repeat (2) @(negedge clk);
        sda_m = mb; oth_low = oth;
        half();
        scl_m = 1'b1;
        half();
        seen = sda_bus;
        scl_m = 1'b0;
    endtask

    task automatic do_start();
        sda_m = 1'b1; oth_low = 1'b0; half();
        scl_m = 1'b1; half();
        sda_m = 1'b0; half();
        scl_m = 1'b0; half();
    endtask

    task automatic do_stop();
        repeat (2) @(negedge clk);
        sda_m = 1'b0; oth_low = 1'b0; half();
        scl_m = 1'b1; half();
        sda_m = 1'b1; half();
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cyc(b[i], 1'b0, s);
        bit_cyc(1'b1, 1'b0, s);
        ack = !s;
    endtask

    task automatic read_byte(input logic mack, input logic oth_en, input logic [7:0] oth_b,
                             output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_cyc(1'b1, oth_en & ~oth_b[i], s);
            b[i] = s;
        end
        bit_cyc(!mack, 1'b0, s);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] b;
        logic s;
        int w0;
        repeat (5) @(negedge clk);
        chk("R11 reset release", sda_oe, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // write to own address
        do_start();
        write_byte({OWN, 1'b0}, ack); chk("R2 own write address ack", ack, 1);
        write_byte(8'hA5, ack);       chk("R4 data byte 1 ack", ack, 1);
        write_byte(8'h3C, ack);       chk("R4 data byte 2 ack", ack, 1);
        do_stop();
        chk("R4 write strobe count", wr_log.size(), 2);
        if (wr_log.size() == 2) begin
            chk("R4 first byte MSB first", wr_log[0], 8'hA5);
            chk("R4 second byte", wr_log[1], 8'h3C);
        end
        chk("R11 idle after stop", sda_oe, 0);
        wr_log.delete();

        // wrong address, then data that must be ignored
        do_start();
        write_byte({7'h11, 1'b0}, ack); chk("R3 mismatched address nack", ack, 0);
        write_byte(8'h00, ack);         chk("R3 data after mismatch nack", ack, 0);
        chk("R3 no write strobe", wr_log.size(), 0);

        // repeated start to own write, then repeated start to read
        do_start();
        write_byte({OWN, 1'b0}, ack); chk("R1 start recovers from ignore", ack, 1);
        do_start();
        write_byte({OWN, 1'b1}, ack); chk("R2 own read address ack", ack, 1);
        read_byte(1'b1, 1'b0, 8'h00, b); chk("R5 read byte 1", b, 8'hC3);
        read_byte(1'b0, 1'b0, 8'h00, b); chk("R5 read byte 2", b, 8'hC2);
        repeat (4) @(negedge clk);
        chk("R5 released after nack", sda_oe, 0);
        do_stop();

        // alert response with alert down
        do_start();
        write_byte(8'h19, ack); chk("R7 alert poll ignored when not latched", ack, 0);
        do_stop();

        // alert response, sole responder
        alert_latched = 1'b1; alert_status = 1'b1;
        do_start();
        write_byte(8'h19, ack); chk("R7 alert poll ack", ack, 1);
        read_byte(1'b0, 1'b0, 8'h00, b); chk("R8 reply byte", b, {OWN, 1'b1});
        do_stop();
        chk("R8 won pulse count", won_cnt, 1);

        // alert response against a lower address
        alert_status = 1'b0;
        w0 = won_cnt;
        do_start();
        write_byte(8'h19, ack); chk("R7 alert poll ack second", ack, 1);
        read_byte(1'b0, 1'b1, {7'h20, 1'b1}, b); chk("R9 reply equals winner", b, {7'h20, 1'b1});
        chk("R9 no won pulse after loss", won_cnt, w0);
        chk("R9 released after loss", sda_oe, 0);
        do_stop();
        alert_latched = 1'b0;

        // timeout while holding acknowledge
        do_start();
        for (int i = 7; i >= 0; i--) bit_cyc(i == 0 ? 1'b0 : OWN[i-1], 1'b0, s);
        repeat (2) @(negedge clk);
        sda_m = 1'b1;
        half();
        chk("R2 ack held low", sda_oe, 1);
        repeat (4000) @(negedge clk);
        chk("R10 still held before limit", sda_oe, 1);
        repeat (1500) @(negedge clk);
        chk("R10 released after limit", sda_oe, 0);
        scl_m = 1'b1;
        half();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule